// File: doc/BRIEF.md
# Four-Channel One-Shot Match Alarm

This block provides four independent one-shot alarms for a system timebase. Each channel holds a 32-bit target. Every clock cycle, the block compares each target with the low 32 bits of a free-running 64-bit time value, which arrives on an input port. The counter that produces that time value belongs to a neighbouring block.

Software uses a simple 32-bit register port to load a target, and that write also arms the channel. When an armed channel sees its target equal to the time input, it latches a raw interrupt flag and disarms itself, so it fires only once. Before it fires, software can cancel a channel by writing ones to the armed register. Raw flags are cleared by writing ones to them.

The raw flags are ORed with a force mask and then ANDed with an enable mask. The result forms a readable status word. Any set status bit drives the single interrupt line. While the timebase asserts its lock input, every register write is discarded.

Top module: `match_alarm_unit`

## Requirements
- R1: After synchronous reset, every target, armed, raw, enable, force and status value reads 0 and `irq` is low.
- R2: A write to target n (byte address 0x10 + 4·n, n = 0..3) stores all 32 data bits, readable at the same address, and sets bit n of the armed register (address 0x20) on the following cycle.
- R3: When armed bit n is 1 and target n equals `time_lo` at a rising edge, raw bit n (address 0x3C, bit n for alarm n) is 1 and armed bit n is 0 after that edge.
- R4: A match on a channel whose armed bit is 0 leaves its raw bit unchanged.
- R5: Writing the armed register clears each armed bit whose data bit is 1, without setting any raw bit; data bits of 0 leave their channels unchanged.
- R6: Writing the raw register clears each raw bit whose data bit is 1. If a channel fires in the same cycle as such a clear, the raw bit ends up 1.
- R7: The enable register (0x40) and the force register (0x44) store data bits 3:0, read back with bits 31:4 as 0, and reset to 0.
- R8: The status register (0x48) reads (raw OR force) AND enable, and `irq` is high exactly when that value is non-zero.
- R9: While `wr_lock` is high, a write changes no register: targets, armed, raw, enable and force all keep their values.
- R10: A read from any address not listed above returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| time_lo | input | 32 | Low 32 bits of the timebase |
| wr_lock | input | 1 | When high, all writes are discarded |
| irq | output | 1 | OR of the masked status bits |

## Verification
Some properties are checked on every cycle by the assertions:
- a match on an armed channel sets its raw flag and disarms it;
- a raw flag never rises on a channel that was disarmed;
- a write of ones to the armed register leaves those bits clear;
- a locked write changes nothing;
- `irq` always follows the masked combination.

Other behaviour can only be shown by the bench's scenarios. These include:
- the priority of a fire over a simultaneous clear;
- the read-back values of every register and of unmapped addresses;
- several channels firing on one shared target;
- the force path raising `irq` while nothing is pending.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int ALARMS = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_TGT_BASE = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ARMED    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RAW      = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_EN       = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_FRC      = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_STAT     = 8'h48;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TGT,
        SEL_ARMED,
        SEL_RAW,
        SEL_EN,
        SEL_FRC,
        SEL_STAT
    } reg_sel_e;

    function automatic logic [ADDR_W-1:0] tgt_ofs(input int idx);
        return OFS_TGT_BASE + ADDR_W'(4 * idx);
    endfunction

    function automatic reg_sel_e classify(input logic [ADDR_W-1:0] a, input int n);
        reg_sel_e s;
        s = SEL_NONE;
        if (a >= OFS_TGT_BASE && a < tgt_ofs(n) && a[1:0] == 2'b00) s = SEL_TGT;
        else if (a == OFS_ARMED) s = SEL_ARMED;
        else if (a == OFS_RAW)   s = SEL_RAW;
        else if (a == OFS_EN)    s = SEL_EN;
        else if (a == OFS_FRC)   s = SEL_FRC;
        else if (a == OFS_STAT)  s = SEL_STAT;
        return s;
    endfunction

endpackage

// File: rtl/alarm_wr_decode.sv
module alarm_wr_decode
    import alarm_pkg::*;
#(
    parameter int N = ALARMS
) (
    input  reg_wr_t      wr,
    input  logic         lock,
    output logic [N-1:0] tgt_we,
    output logic [N-1:0] armed_clr,
    output logic [N-1:0] raw_clr,
    output logic         en_we,
    output logic         frc_we
);
    logic     accept;
    reg_sel_e sel;

    assign accept = wr.valid && !lock;
    assign sel    = classify(wr.addr, N);

    always_comb begin
        tgt_we    = '0;
        armed_clr = '0;
        raw_clr   = '0;
        en_we     = 1'b0;
        frc_we    = 1'b0;
        if (accept) begin
            unique case (sel)
                SEL_TGT: begin
                    for (int i = 0; i < N; i++) begin
                        if (wr.addr == tgt_ofs(i)) tgt_we[i] = 1'b1;
                    end
                end
                SEL_ARMED: armed_clr = wr.data[N-1:0];
                SEL_RAW:   raw_clr   = wr.data[N-1:0];
                SEL_EN:    en_we     = 1'b1;
                SEL_FRC:   frc_we    = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/alarm_slot.sv
module alarm_slot
    import alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tgt_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              disarm,
    input  logic              raw_clr,
    input  logic [DATA_W-1:0] time_lo,
    output logic [DATA_W-1:0] target,
    output logic              armed,
    output logic              raw,
    output logic              hit
);
    assign hit = armed && (target == time_lo);

    always_ff @(posedge clk) begin
        if (rst) begin
            target <= '0;
            armed  <= 1'b0;
            raw    <= 1'b0;
        end else begin
            if (tgt_we) target <= wdata;

            if (tgt_we)              armed <= 1'b1;
            else if (hit || disarm)  armed <= 1'b0;

            if (hit)          raw <= 1'b1;
            else if (raw_clr) raw <= 1'b0;
        end
    end
endmodule

// File: rtl/alarm_irq_mask.sv
module alarm_irq_mask
    import alarm_pkg::*;
#(
    parameter int N = ALARMS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_we,
    input  logic         frc_we,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] raw,
    output logic [N-1:0] en,
    output logic [N-1:0] frc,
    output logic [N-1:0] status,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= '0;
            frc <= '0;
        end else begin
            if (en_we)  en  <= wdata;
            if (frc_we) frc <= wdata;
        end
    end

    assign status = (raw | frc) & en;
    assign irq    = |status;
endmodule

// File: rtl/match_alarm_unit.sv
module match_alarm_unit
    import alarm_pkg::*;
#(
    parameter int N_ALARMS = ALARMS,
    parameter int AW       = ADDR_W,
    parameter int DW       = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] time_lo,
    input  logic          wr_lock,
    output logic          irq
);
    reg_wr_t                      wr;
    logic [N_ALARMS-1:0]          tgt_we, armed_clr, raw_clr;
    logic                         en_we, frc_we;
    logic [N_ALARMS-1:0][DW-1:0]  tgt_arr;
    logic [N_ALARMS-1:0]          armed_vec, raw_vec, hit_vec;
    logic [N_ALARMS-1:0]          en_vec, frc_vec, stat_vec;

    assign wr.valid = reg_wr;
    assign wr.addr  = reg_addr;
    assign wr.data  = reg_wdata;

    alarm_wr_decode #(.N(N_ALARMS)) u_dec (
        .wr        (wr),
        .lock      (wr_lock),
        .tgt_we    (tgt_we),
        .armed_clr (armed_clr),
        .raw_clr   (raw_clr),
        .en_we     (en_we),
        .frc_we    (frc_we)
    );

    for (genvar g = 0; g < N_ALARMS; g++) begin : g_slot
        alarm_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .tgt_we  (tgt_we[g]),
            .wdata   (reg_wdata),
            .disarm  (armed_clr[g]),
            .raw_clr (raw_clr[g]),
            .time_lo (time_lo),
            .target  (tgt_arr[g]),
            .armed   (armed_vec[g]),
            .raw     (raw_vec[g]),
            .hit     (hit_vec[g])
        );
    end

    alarm_irq_mask #(.N(N_ALARMS)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .en_we  (en_we),
        .frc_we (frc_we),
        .wdata  (reg_wdata[N_ALARMS-1:0]),
        .raw    (raw_vec),
        .en     (en_vec),
        .frc    (frc_vec),
        .status (stat_vec),
        .irq    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (classify(reg_addr, N_ALARMS))
            SEL_TGT: begin
                for (int i = 0; i < N_ALARMS; i++) begin
                    if (reg_addr == tgt_ofs(i)) reg_rdata = tgt_arr[i];
                end
            end
            SEL_ARMED: reg_rdata = DW'(armed_vec);
            SEL_RAW:   reg_rdata = DW'(raw_vec);
            SEL_EN:    reg_rdata = DW'(en_vec);
            SEL_FRC:   reg_rdata = DW'(frc_vec);
            SEL_STAT:  reg_rdata = DW'(stat_vec);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk
    import alarm_pkg::*;
#(
    parameter int N  = ALARMS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [AW-1:0]        reg_addr,
    input logic [DW-1:0]        reg_wdata,
    input logic [DW-1:0]        time_lo,
    input logic                 wr_lock,
    input logic                 irq,
    input logic [N-1:0][DW-1:0] tgt,
    input logic [N-1:0]         armed,
    input logic [N-1:0]         raw,
    input logic [N-1:0]         en,
    input logic [N-1:0]         frc
);
    logic [N-1:0] seen_hit;
    logic         wr_ok;

    assign wr_ok = reg_wr && !wr_lock;

    always_comb begin
        for (int i = 0; i < N; i++) seen_hit[i] = armed[i] && (tgt[i] == time_lo);
    end

    AST_FIRE_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
        (|seen_hit) |=> ((raw & $past(seen_hit)) == $past(seen_hit))); // R3

    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (rst)
        ((|seen_hit) && !wr_ok) |=> ((armed & $past(seen_hit)) == '0)); // R3

    AST_NO_RISE_UNARMED: assert property (@(posedge clk) disable iff (rst)
        ((raw & ~$past(raw) & ~$past(armed)) == '0)); // R4

    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && reg_addr == OFS_ARMED) |=> ((armed & $past(reg_wdata[N-1:0])) == '0)); // R5

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wr_lock) |=> ($stable(en) && $stable(frc) && $stable(tgt))); // R9

    AST_IRQ_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq == (|((raw | frc) & en))); // R8

    for (genvar g = 0; g < N; g++) begin : g_arm
        AST_TARGET_ARMS: assert property (@(posedge clk) disable iff (rst)
            (wr_ok && reg_addr == tgt_ofs(g)) |=> (armed[g] && tgt[g] == $past(reg_wdata))); // R2
    end
endmodule

bind match_alarm_unit alarm_unit_chk #(.N(N_ALARMS), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .time_lo   (time_lo),
    .wr_lock   (wr_lock),
    .irq       (irq),
    .tgt       (tgt_arr),
    .armed     (armed_vec),
    .raw       (raw_vec),
    .en        (en_vec),
    .frc       (frc_vec)
);

// File: tb/match_alarm_unit_test.sv
module match_alarm_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] time_lo = 32'h0;
    logic        wr_lock = 1'b0;
    logic        irq;

    int vectors = 0;
    int errors  = 0;

    logic [31:0] m_tgt [4];
    bit   [3:0]  m_arm, m_raw, m_en, m_frc;

    always #4 clk = ~clk;

    match_alarm_unit uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_lo(time_lo),
        .wr_lock(wr_lock), .irq(irq)
    );

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        case (a)
            8'h10: return m_tgt[0];
            8'h14: return m_tgt[1];
            8'h18: return m_tgt[2];
            8'h1C: return m_tgt[3];
            8'h20: return {28'h0, m_arm};
            8'h3C: return {28'h0, m_raw};
            8'h40: return {28'h0, m_en};
            8'h44: return {28'h0, m_frc};
            8'h48: return {28'h0, (m_raw | m_frc) & m_en};
            default: return 32'h0;
        endcase
    endfunction

    // one clock: drive inputs, predict next state, compare irq after the edge
    task automatic tick(input bit we, input logic [7:0] a, input logic [31:0] d, input string tag);
        bit [3:0]    n_arm, n_raw, n_en, n_frc, hit;
        logic [31:0] n_tgt [4];
        bit          ok;
        reg_wr = we; reg_addr = a; reg_wdata = d;
        ok = we && !wr_lock;
        n_arm = m_arm; n_raw = m_raw; n_en = m_en; n_frc = m_frc;
        for (int i = 0; i < 4; i++) begin
            n_tgt[i] = m_tgt[i];
            hit[i] = m_arm[i] && (m_tgt[i] == time_lo);
            if (ok && a == 8'(8'h10 + 4 * i)) begin
                n_tgt[i] = d; n_arm[i] = 1'b1;
            end else if (hit[i] || (ok && a == 8'h20 && d[i])) begin
                n_arm[i] = 1'b0;
            end
            if (hit[i]) n_raw[i] = 1'b1;
            else if (ok && a == 8'h3C && d[i]) n_raw[i] = 1'b0;
        end
        if (ok && a == 8'h40) n_en  = d[3:0];
        if (ok && a == 8'h44) n_frc = d[3:0];
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 4; i++) m_tgt[i] = n_tgt[i];
        m_arm = n_arm; m_raw = n_raw; m_en = n_en; m_frc = n_frc;
        reg_wr = 1'b0;
        vectors++;
        if (irq !== (|((m_raw | m_frc) & m_en))) begin
            errors++;
            $display("FAIL %s (R8 irq): actual %b expected %b", tag, irq, |((m_raw | m_frc) & m_en));
        end
    endtask

    task automatic peek(input logic [7:0] a, input string tag);
        logic [31:0] exp;
        reg_wr = 1'b0; reg_addr = a;
        #1;
        exp = model_rd(a);
        vectors++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %h: actual %h expected %h", tag, a, reg_rdata, exp);
        end
        tick(1'b0, a, 32'h0, tag);
    endtask

    task automatic expect_val(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        vectors++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %h: actual %h expected %h", tag, a, reg_rdata, exp);
        end
        tick(1'b0, a, 32'h0, tag);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_tgt[i] = '0;
        m_arm = '0; m_raw = '0; m_en = '0; m_frc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        foreach (m_tgt[i]) peek(8'(8'h10 + 4 * i), "R1");
        peek(8'h20, "R1"); peek(8'h3C, "R1"); peek(8'h40, "R1");
        peek(8'h44, "R1"); peek(8'h48, "R1");
        expect_val(8'h48, 32'h0, "R1");

        // R2: target write stores and arms
        tick(1'b1, 8'h10, 32'd100, "R2");
        expect_val(8'h10, 32'd100, "R2");
        expect_val(8'h20, 32'h1, "R2");

        // R3: match fires, disarms, sets raw
        time_lo = 32'd100;
        tick(1'b0, 8'h00, 32'h0, "R3");
        time_lo = 32'd101;
        expect_val(8'h3C, 32'h1, "R3");
        expect_val(8'h20, 32'h0, "R3");

        // R8: enabling raises irq
        tick(1'b1, 8'h40, 32'h1, "R8");
        peek(8'h48, "R8");

        // R6: write-one-to-clear, zeros leave bits alone
        tick(1'b1, 8'h3C, 32'h0, "R6");
        expect_val(8'h3C, 32'h1, "R6");
        tick(1'b1, 8'h3C, 32'h1, "R6");
        expect_val(8'h3C, 32'h0, "R6");

        // R4: match while disarmed has no effect
        time_lo = 32'd100;
        tick(1'b0, 8'h00, 32'h0, "R4");
        expect_val(8'h3C, 32'h0, "R4");

        // R5: early disarm, no fire at its target
        time_lo = 32'd0;
        tick(1'b1, 8'h14, 32'd50, "R5");
        tick(1'b1, 8'h18, 32'd60, "R5");
        tick(1'b1, 8'h20, 32'h2, "R5");
        expect_val(8'h20, 32'h4, "R5");
        time_lo = 32'd50;
        tick(1'b0, 8'h00, 32'h0, "R5");
        expect_val(8'h3C, 32'h0, "R5");
        tick(1'b1, 8'h20, 32'h4, "R5");
        expect_val(8'h20, 32'h0, "R5");

        // R6: fire and clear in the same cycle, set wins
        time_lo = 32'd0;
        tick(1'b1, 8'h18, 32'd7, "R6");
        time_lo = 32'd7;
        tick(1'b1, 8'h3C, 32'h4, "R6");
        time_lo = 32'd8;
        expect_val(8'h3C, 32'h4, "R6");

        // R3: two channels on one target fire together
        tick(1'b1, 8'h10, 32'hDEAD_0000, "R3");
        tick(1'b1, 8'h1C, 32'hDEAD_0000, "R3");
        time_lo = 32'hDEAD_0000;
        tick(1'b0, 8'h00, 32'h0, "R3");
        time_lo = 32'd9;
        expect_val(8'h3C, 32'hD, "R3");
        expect_val(8'h20, 32'h0, "R3");
        tick(1'b1, 8'h3C, 32'hF, "R6");

        // R7 / R8: force through enable, upper bits dropped
        tick(1'b1, 8'h44, 32'hFFFF_FFF8, "R7");
        expect_val(8'h44, 32'h8, "R7");
        tick(1'b1, 8'h40, 32'hFFFF_FFFF, "R7");
        expect_val(8'h40, 32'hF, "R7");
        expect_val(8'h48, 32'h8, "R8");
        tick(1'b1, 8'h40, 32'h7, "R8");
        expect_val(8'h48, 32'h0, "R8");
        tick(1'b1, 8'h44, 32'h0, "R7");

        // R9: locked writes are discarded
        wr_lock = 1'b1;
        tick(1'b1, 8'h1C, 32'h1234_5678, "R9");
        tick(1'b1, 8'h40, 32'h0, "R9");
        tick(1'b1, 8'h44, 32'hF, "R9");
        expect_val(8'h1C, 32'hDEAD_0000, "R9");
        expect_val(8'h20, 32'h0, "R9");
        expect_val(8'h40, 32'h7, "R9");
        expect_val(8'h44, 32'h0, "R9");
        wr_lock = 1'b0;

        // R10: unmapped addresses read zero
        expect_val(8'h04, 32'h0, "R10");
        expect_val(8'h24, 32'h0, "R10");
        expect_val(8'h4C, 32'h0, "R10");
        expect_val(8'h11, 32'h0, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule